// File: doc/BRIEF.md
# Strided Ramp Table Generator

This block produces a periodic ramp by stepping through an externally held lookup table. The table is 1024 words of 16 bits by default. The block drives the table read address and reads the word back combinationally on the same cycle. A 16-bit control word sets two things: which of fifteen output channels receives the ramp, and how many table entries are skipped per sample. A larger stride walks the table faster, so stride 2 gives twice the ramp frequency of stride 1.

On every sample strobe the block samples the control word. If the channel field names a valid channel, the block does three things:
- it latches the table word at the current index onto its data output;
- it raises a one-cycle valid pulse, tagged with the channel number;
- it asserts that channel's drive enable, and no other.

It then advances the index by the stride, wrapping modulo the table depth. A channel field of zero, or any value above fifteen, turns the ramp off. Turning it off releases every channel enable and returns the index to entry zero, so the ramp always restarts from the start of the table.

Top module: `ramp_gen_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first sample strobe, `out_valid` is 0, `ch_en` is all zeros, `out_ch` is 0, `out_data` is 0 and `tbl_addr` is 0.
- R2: A strobe with channel field `ctrl[7:0]` equal to 0 gives, on the next cycle, `out_valid` 0 and `ch_en` all zeros.
- R3: A strobe with channel field value k in 1..15 gives, on the next cycle:
  - `out_ch` equal to k;
  - exactly one bit of `ch_en` set, at bit position k-1 (bit 0 is channel 1).

  The enable stays on that channel until the next strobe.
- R4: A channel field value from 16 to 255 is invalid and is treated exactly like 0, including the index reset of R8.
- R5: The stride is `ctrl[15:8]`. Each strobe with a valid channel moves `tbl_addr` forward by the stride.
- R6: The index wraps modulo the table depth of 1024. The next address is (address + stride) mod 1024.
- R7: A stride of 0 with a valid channel leaves `tbl_addr` unchanged, so every sample carries the same table word.
- R8: A strobe with an off or invalid channel sets `tbl_addr` to 0. The first valid strobe after that presents table entry 0.
- R9: `ctrl` is sampled only on a strobe. Between strobes, changing it alters none of the outputs. A new channel takes effect with the next strobe.
- R10: A strobe with a valid channel places on `out_data`, in the next cycle, the table word read at the address shown before that strobe. `out_data` holds between strobes. `out_valid` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 16 | Stride in [15:8], channel select in [7:0] |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| tbl_data | input | 16 | Table word at `tbl_addr`, read combinationally |
| tbl_addr | output | 10 | Current table index |
| out_data | output | 16 | Latched ramp sample |
| out_ch | output | 4 | Channel number of the current sample |
| out_valid | output | 1 | One-cycle pulse per produced sample |
| ch_en | output | 15 | One-hot drive enable per channel, bit k-1 for channel k |

## Verification
The assertions assume the following about the inputs:
- `ctrl` and `smp_stb` are stable around the clock edge.
- The stride stays below the table depth, which the 8-bit field guarantees whenever the depth is at least 256.
- `tbl_data` settles within the same cycle that `tbl_addr` changes.

The stimulus respects these rules by driving every input on the falling edge. The bench serves the table as a fixed arithmetic function of the address. It exercises several stride and channel combinations, strobes at irregular intervals, and changes `ctrl` between strobes.

// File: rtl/ramp_gen_pkg.sv
package ramp_gen_pkg;
    localparam int CTRL_W   = 16;
    localparam int SEL_W    = 8;
    localparam int STRIDE_W = 8;
    localparam int CH_W     = 4;
    localparam int NUM_CH   = 15;

    typedef struct packed {
        logic                on;
        logic [CH_W-1:0]     ch;
        logic [STRIDE_W-1:0] stride;
    } ramp_cmd_t;
endpackage

// File: rtl/ramp_ctrl_decode.sv
module ramp_ctrl_decode
    import ramp_gen_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output ramp_cmd_t         cmd
);
    logic [SEL_W-1:0] sel;

    always_comb begin
        sel        = ctrl[SEL_W-1:0];
        cmd.stride = ctrl[CTRL_W-1:SEL_W];
        // valid channels are 1..NUM_CH; zero and anything above are "off"
        cmd.on     = (sel != '0) && (sel <= SEL_W'(NUM_CH));
        cmd.ch     = cmd.on ? sel[CH_W-1:0] : '0;
    end
endmodule

// File: rtl/ramp_index_step.sv
module ramp_index_step #(
    parameter int DEPTH    = 1024,
    parameter int STRIDE_W = 8,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic [AW-1:0]       idx,
    input  logic [STRIDE_W-1:0] stride,
    output logic [AW-1:0]       idx_next
);
    logic [AW:0] sum;

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            // power-of-two depth: wrap is a plain truncation
            always_comb begin
                sum      = {1'b0, idx} + (AW+1)'(stride);
                idx_next = sum[AW-1:0];
            end
        end else begin : g_any
            // arbitrary depth: one conditional subtract (stride < DEPTH)
            always_comb begin
                sum = {1'b0, idx} + (AW+1)'(stride);
                if (sum >= (AW+1)'(DEPTH)) idx_next = AW'(sum - (AW+1)'(DEPTH));
                else                        idx_next = sum[AW-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/ramp_chan_route.sv
module ramp_chan_route #(
    parameter int NUM_CH = 15,
    parameter int CH_W   = 4
) (
    input  logic              en,
    input  logic [CH_W-1:0]   ch,
    output logic [NUM_CH-1:0] ch_en
);
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign ch_en[i] = en && (ch == CH_W'(i + 1));
        end
    endgenerate
endmodule

// File: rtl/ramp_gen_top.sv
module ramp_gen_top
    import ramp_gen_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] tbl_data,
    output logic [AW-1:0]     tbl_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [CH_W-1:0]   out_ch,
    output logic              out_valid,
    output logic [NUM_CH-1:0] ch_en
);
    typedef struct packed {
        logic [AW-1:0]     idx;
        logic              en;
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] data;
        logic              valid;
    } ramp_state_t;

    ramp_state_t st_d, st_q;
    ramp_cmd_t   cmd;
    logic [AW-1:0] idx_step;

    ramp_ctrl_decode u_decode (
        .ctrl (ctrl),
        .cmd  (cmd)
    );

    ramp_index_step #(
        .DEPTH    (DEPTH),
        .STRIDE_W (STRIDE_W)
    ) u_step (
        .idx      (st_q.idx),
        .stride   (cmd.stride),
        .idx_next (idx_step)
    );

    ramp_chan_route #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_route (
        .en    (st_q.en),
        .ch    (st_q.ch),
        .ch_en (ch_en)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (smp_stb) begin
            if (cmd.on) begin
                st_d.data  = tbl_data;
                st_d.idx   = idx_step;
                st_d.en    = 1'b1;
                st_d.ch    = cmd.ch;
                st_d.valid = 1'b1;
            end else begin
                // off or invalid: release channels, restart table walk
                st_d.idx = '0;
                st_d.en  = 1'b0;
                st_d.ch  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tbl_addr  = st_q.idx;
    assign out_data  = st_q.data;
    assign out_ch    = st_q.ch;
    assign out_valid = st_q.valid;
endmodule

// File: rtl/ramp_gen_checker.sv
module ramp_gen_checker
    import ramp_gen_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl,
    input logic              smp_stb,
    input logic [DATA_W-1:0] tbl_data,
    input logic [AW-1:0]     tbl_addr,
    input logic [DATA_W-1:0] out_data,
    input logic [CH_W-1:0]   out_ch,
    input logic              out_valid,
    input logic [NUM_CH-1:0] ch_en
);
    logic sel_ok;
    logic sel_zero;
    logic [AW-1:0] addr_wrapped;

    assign sel_zero = (ctrl[7:0] == 8'd0);
    assign sel_ok   = !sel_zero && (ctrl[7:0] <= 8'd15);
    assign addr_wrapped = AW'((int'(tbl_addr) + int'(ctrl[15:8])) % DEPTH);

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && sel_zero |=> !out_valid && ch_en == '0);

    p_route_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && sel_ok |=> out_ch == $past(ctrl[3:0]) && $onehot0(ch_en)
                               && ch_en[out_ch - 4'd1]);

    p_invalid_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && !sel_ok && !sel_zero |=> !out_valid && ch_en == '0);

    p_stride_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && sel_ok |=> tbl_addr == $past(addr_wrapped));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && !sel_ok |=> tbl_addr == '0);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(tbl_addr) && $stable(out_data) && $stable(ch_en)
                     && $stable(out_ch));

    p_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && sel_ok |=> out_valid && out_data == $past(tbl_data));

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> !out_valid);
endmodule

bind ramp_gen_top ramp_gen_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_checker (.*);

// File: tb/ramp_gen_top_bench.sv
module ramp_gen_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl = '0;
    logic        smp_stb = 1'b0;
    logic [15:0] tbl_data;
    logic [9:0]  tbl_addr;
    logic [15:0] out_data;
    logic [3:0]  out_ch;
    logic        out_valid;
    logic [14:0] ch_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int          m_idx = 0;
    bit          m_en = 0;
    int          m_ch = 0;
    logic [15:0] m_data = '0;
    bit          m_valid = 0;
    string       tag = "R1";

    function automatic logic [15:0] tbl_f(int a);
        return 16'((a * 40503 + 4660) & 16'hffff);
    endfunction

    assign tbl_data = tbl_f(int'(tbl_addr));

    always #(CLK_PERIOD/2) clk = ~clk;

    ramp_gen_top u_ramp_gen_top (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .smp_stb(smp_stb),
        .tbl_data(tbl_data), .tbl_addr(tbl_addr), .out_data(out_data),
        .out_ch(out_ch), .out_valid(out_valid), .ch_en(ch_en)
    );

    task automatic check(bit ok, string field, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, field, act, exp);
        end
    endtask

    task automatic compare();
        int exp_en;
        exp_en = m_en ? (1 << (m_ch - 1)) : 0;
        check(out_valid == m_valid, "out_valid", int'(out_valid), int'(m_valid));
        check(out_data == m_data, "out_data", int'(out_data), int'(m_data));
        check(int'(out_ch) == m_ch, "out_ch", int'(out_ch), m_ch);
        check(int'(ch_en) == exp_en, "ch_en", int'(ch_en), exp_en);
        check(int'(tbl_addr) == m_idx, "tbl_addr", int'(tbl_addr), m_idx);
    endtask

    // one cycle: compare at falling edge, drive, advance model
    task automatic cyc(bit stb, logic [15:0] c);
        int sel, str;
        @(negedge clk);
        compare();
        smp_stb = stb;
        ctrl    = c;
        sel = int'(c[7:0]);
        str = int'(c[15:8]);
        m_valid = 0;
        if (stb) begin
            if (sel >= 1 && sel <= 15) begin
                m_data  = tbl_f(m_idx);
                m_idx   = (m_idx + str) % DEPTH;
                m_en    = 1;
                m_ch    = sel;
                m_valid = 1;
            end else begin
                m_idx = 0;
                m_en  = 0;
                m_ch  = 0;
            end
        end
    endtask

    task automatic run(int n, int gap, logic [15:0] c);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, c);
            for (int g = 0; g < gap; g++) cyc(1'b0, c);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        // R1: reset state, during and after reset
        tag = "R1";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1'b0, 16'h0105);

        tag = "R5"; run(10, 1, 16'h0103);      // stride 1, channel 3
        tag = "R5"; run(8, 0, 16'h020F);       // stride 2, channel 15
        // R9: ctrl moves between strobes without effect
        tag = "R9";
        cyc(1'b0, 16'h0000); cyc(1'b0, 16'h05C8); cyc(1'b0, 16'h0907);
        run(3, 2, 16'h0107);                   // new channel only at strobe
        tag = "R6"; run(12, 0, 16'hFF01);      // stride 255 wraps repeatedly
        tag = "R7"; run(5, 1, 16'h0009);       // stride 0 holds index
        tag = "R2"; run(3, 1, 16'h0400);       // channel 0 off
        tag = "R8"; run(4, 1, 16'h0304);       // restart from entry 0
        tag = "R4"; run(2, 1, 16'h01C8);       // 200 invalid
        tag = "R4"; run(1, 1, 16'h0110);       // 16 invalid
        tag = "R8"; run(3, 0, 16'h0302);
        tag = "R3";
        for (int k = 1; k <= 15; k++) run(1, 1, {8'd7, 8'(k)});
        // R10: irregular strobes, mixed control words
        tag = "R10";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [15:0] c;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = {lfsr[15:8], 3'b000, lfsr[4:0]};
            cyc(lfsr[6] | lfsr[2], c);
        end
        @(negedge clk);
        compare();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule